// File: doc/BRIEF.md
# Back-End Soft-Start Threshold and Light-Load Pulse Skipper

This block sits beside the back-end (output-stage) pulse-width modulator of a power-conversion controller. It produces the digital code that a DAC converts into the peak-current limit threshold, and it decides, once per switching cycle, whether the modulator should drop its output pulse.

Whenever either soft-start cause is active, the threshold code is parked at a low floor. The two causes are the supply-low (startup) condition and the output-short detect. Once both causes go away, a prescaled timer moves the code upward in equal steps until it reaches a peak value. One tick later the code settles at the normal current-limit level. Any new cause during the ramp or in normal running sends the code straight back to the floor and restarts the timer.

Independently of soft start, the modulator reports the measured comparator duty of the cycle that just ended, together with its cycle-start strobe. If that duty is below a fixed light-load fraction, the pulse of the new cycle is skipped. Skipping goes on until a report at or above the fraction arrives. The decision is taken only at the strobe, so a pulse that is already running is never cut short.

Top module: `bk_softstart_gate`

## Requirements
- R1: After reset, `ilim_code` equals FLOOR_CODE and `skip_pulse` is 0.
- R2: While `trig_uvlo` or `trig_short` is 1, `ilim_code` equals FLOOR_CODE from the clock edge after the trigger is sampled, and it stays there for as long as either trigger is 1.
- R3: Call the first edge that samples both triggers low edge 0. At edge n, with k = floor(n / TICK_DIV), `ilim_code` equals FLOOR_CODE + k*STEP for 0 <= k < NUM_STEPS, where STEP = (PEAK_CODE - FLOOR_CODE) / NUM_STEPS. The code never decreases during the ramp.
- R4: When k = NUM_STEPS, `ilim_code` equals PEAK_CODE exactly, including when the division leaves a remainder. For k > NUM_STEPS it equals NORMAL_CODE, and it holds that value until a trigger arrives.
- R5: A trigger during the ramp or in normal running forces FLOOR_CODE at the next edge. After release, the step timing of R3 restarts from zero.
- R6: At an edge with `cyc_start` = 1 and `duty_meas` < SKIP_DUTY, `skip_pulse` becomes 1. `duty_meas` is unsigned duty in units of 1/2^DUTY_W, and the default SKIP_DUTY of 16 with an 8-bit width is 6.25 %.
- R7: At an edge with `cyc_start` = 1 and `duty_meas` >= SKIP_DUTY, `skip_pulse` becomes 0. The output resumes in the cycle that follows the report.
- R8: `skip_pulse` changes only at edges where `cyc_start` = 1. Changes on `duty_meas`, `trig_uvlo` or `trig_short` between strobes leave it unchanged.

Ports are listed below in declaration order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_uvlo | input | 1 | Supply-low soft-start cause |
| trig_short | input | 1 | Output-short soft-start cause |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| duty_meas | input | DUTY_W | Measured duty of the cycle just ended, valid with `cyc_start` |
| ilim_code | output | CODE_W | Current-limit threshold DAC code |
| skip_pulse | output | 1 | Suppress the output pulse of the current cycle |

## Verification
A ramp counter or step counter in the wrong state shows up as a wrong `ilim_code` on the very next tick. Since every step lands on a predictable edge, sampling the code each cycle against the closed-form schedule exposes an early, late or missing step within one tick period. A wrong clamp is caught at the final step. A phase machine stuck outside the hold state shows up one edge after a trigger, because the code fails to return to the floor. A skip flag latched at the wrong time or with a wrong compare appears on `skip_pulse` one edge after the strobe. A flag that moves between strobes is caught by the first sample after a disturbing input change.

// File: rtl/bkss_pkg.sv
package bkss_pkg;

    typedef enum logic [1:0] {
        SS_HOLD = 2'd0,
        SS_RAMP = 2'd1,
        SS_RUN  = 2'd2
    } ss_phase_e;

    typedef struct packed {
        logic      light;
        logic      strobe;
    } skip_evt_t;

    function automatic int unsigned ramp_step(input int unsigned lo,
                                              input int unsigned hi,
                                              input int unsigned n);
        return (hi - lo) / n;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/bkss_tick_gen.sv
module bkss_tick_gen #(
    parameter int unsigned TICK_DIV = 2703
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    import bkss_pkg::*;

    localparam int unsigned CW = cnt_width(TICK_DIV);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bkss_ramp_fsm.sv
module bkss_ramp_fsm #(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned FLOOR_CODE  = 15,
    parameter int unsigned PEAK_CODE   = 200,
    parameter int unsigned NORMAL_CODE = 150,
    parameter int unsigned NUM_STEPS   = 37
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_any,
    input  logic              tick,
    output logic              ramp_run,
    output logic [CODE_W-1:0] code
);
    import bkss_pkg::*;

    localparam int unsigned STEP = ramp_step(FLOOR_CODE, PEAK_CODE, NUM_STEPS);
    localparam int unsigned SW   = $clog2(NUM_STEPS + 1);

    ss_phase_e         phase_q;
    logic [SW-1:0]     nsteps_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || trig_any) begin
            phase_q  <= SS_HOLD;
            nsteps_q <= '0;
            code_q   <= CODE_W'(FLOOR_CODE);
        end else begin
            unique case (phase_q)
                SS_HOLD: begin
                    phase_q <= SS_RAMP;
                end
                SS_RAMP: begin
                    if (tick) begin
                        if (nsteps_q == SW'(NUM_STEPS)) begin
                            phase_q <= SS_RUN;
                            code_q  <= CODE_W'(NORMAL_CODE);
                        end else if (nsteps_q == SW'(NUM_STEPS - 1)) begin
                            code_q   <= CODE_W'(PEAK_CODE);
                            nsteps_q <= nsteps_q + 1'b1;
                        end else begin
                            code_q   <= code_q + CODE_W'(STEP);
                            nsteps_q <= nsteps_q + 1'b1;
                        end
                    end
                end
                SS_RUN: begin
                    code_q <= CODE_W'(NORMAL_CODE);
                end
                default: begin
                    phase_q <= SS_HOLD;
                    code_q  <= CODE_W'(FLOOR_CODE);
                end
            endcase
        end
    end

    assign ramp_run = (phase_q == SS_RAMP);
    assign code     = code_q;
endmodule

// File: rtl/bkss_skip_gate.sv
module bkss_skip_gate #(
    parameter int unsigned DUTY_W    = 8,
    parameter int unsigned SKIP_DUTY = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic [DUTY_W-1:0] duty_meas,
    output logic              skip
);
    import bkss_pkg::*;

    skip_evt_t evt;
    logic      skip_q;

    always_comb begin
        evt.strobe = cyc_start;
        evt.light  = (duty_meas < DUTY_W'(SKIP_DUTY));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
        end else if (evt.strobe) begin
            skip_q <= evt.light;
        end
    end

    assign skip = skip_q;
endmodule

// File: rtl/bk_softstart_gate.sv
module bk_softstart_gate #(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned FLOOR_CODE  = 15,
    parameter int unsigned PEAK_CODE   = 200,
    parameter int unsigned NORMAL_CODE = 150,
    parameter int unsigned NUM_STEPS   = 37,
    parameter int unsigned TICK_DIV    = 2703,
    parameter int unsigned DUTY_W      = 8,
    parameter int unsigned SKIP_DUTY   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_uvlo,
    input  logic              trig_short,
    input  logic              cyc_start,
    input  logic [DUTY_W-1:0] duty_meas,
    output logic [CODE_W-1:0] ilim_code,
    output logic              skip_pulse
);
    logic trig_any;
    logic ramp_run;
    logic tick;

    assign trig_any = trig_uvlo | trig_short;

    bkss_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (ramp_run),
        .tick (tick)
    );

    bkss_ramp_fsm #(
        .CODE_W      (CODE_W),
        .FLOOR_CODE  (FLOOR_CODE),
        .PEAK_CODE   (PEAK_CODE),
        .NORMAL_CODE (NORMAL_CODE),
        .NUM_STEPS   (NUM_STEPS)
    ) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .trig_any (trig_any),
        .tick     (tick),
        .ramp_run (ramp_run),
        .code     (ilim_code)
    );

    bkss_skip_gate #(
        .DUTY_W    (DUTY_W),
        .SKIP_DUTY (SKIP_DUTY)
    ) u_skip (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .duty_meas (duty_meas),
        .skip      (skip_pulse)
    );
endmodule

// File: rtl/bk_softstart_chk.sv
module bk_softstart_chk #(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned FLOOR_CODE  = 15,
    parameter int unsigned PEAK_CODE   = 200,
    parameter int unsigned NORMAL_CODE = 150,
    parameter int unsigned DUTY_W      = 8,
    parameter int unsigned SKIP_DUTY   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_uvlo,
    input logic              trig_short,
    input logic              cyc_start,
    input logic [DUTY_W-1:0] duty_meas,
    input logic [CODE_W-1:0] ilim_code,
    input logic              skip_pulse
);
    a_r2_hold_floor: assert property (@(posedge clk) disable iff (rst)
        (trig_uvlo || trig_short) |=> (ilim_code == CODE_W'(FLOOR_CODE)));

    a_r3_no_drop: assert property (@(posedge clk) disable iff (rst)
        (!trig_uvlo && !trig_short && ilim_code != CODE_W'(NORMAL_CODE))
        |=> (ilim_code >= $past(ilim_code) || ilim_code == CODE_W'(NORMAL_CODE)));

    a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
        (ilim_code >= CODE_W'(FLOOR_CODE)) && (ilim_code <= CODE_W'(PEAK_CODE)));

    a_r6_skip_set: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && duty_meas < DUTY_W'(SKIP_DUTY)) |=> skip_pulse);

    a_r7_skip_clear: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && duty_meas >= DUTY_W'(SKIP_DUTY)) |=> !skip_pulse);

    a_r8_skip_hold: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> $stable(skip_pulse));
endmodule

bind bk_softstart_gate bk_softstart_chk #(
    .CODE_W      (CODE_W),
    .FLOOR_CODE  (FLOOR_CODE),
    .PEAK_CODE   (PEAK_CODE),
    .NORMAL_CODE (NORMAL_CODE),
    .DUTY_W      (DUTY_W),
    .SKIP_DUTY   (SKIP_DUTY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_uvlo  (trig_uvlo),
    .trig_short (trig_short),
    .cyc_start  (cyc_start),
    .duty_meas  (duty_meas),
    .ilim_code  (ilim_code),
    .skip_pulse (skip_pulse)
);

// File: tb/sim_bk_softstart_gate.sv
`timescale 1ns/1ps
module sim_bk_softstart_gate;
    localparam int unsigned CW  = 8;
    localparam int unsigned FL  = 15;
    localparam int unsigned PK  = 200;
    localparam int unsigned NM  = 150;
    localparam int unsigned NS  = 4;
    localparam int unsigned DV  = 5;
    localparam int unsigned DW  = 8;
    localparam int unsigned THR = 16;
    localparam int unsigned STP = (PK - FL) / NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_uvlo = 1'b1;
    logic          trig_short = 1'b0;
    logic          cyc_start = 1'b0;
    logic [DW-1:0] duty_meas = '0;
    logic [CW-1:0] ilim_code;
    logic          skip_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bk_softstart_gate #(
        .CODE_W(CW), .FLOOR_CODE(FL), .PEAK_CODE(PK), .NORMAL_CODE(NM),
        .NUM_STEPS(NS), .TICK_DIV(DV), .DUTY_W(DW), .SKIP_DUTY(THR)
    ) u0 (
        .clk(clk), .rst(rst), .trig_uvlo(trig_uvlo), .trig_short(trig_short),
        .cyc_start(cyc_start), .duty_meas(duty_meas),
        .ilim_code(ilim_code), .skip_pulse(skip_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int n);
        int k;
        k = n / DV;
        if (k < NS) return FL + k * STP;
        if (k == NS) return PK;
        return NM;
    endfunction

    // release all triggers at a negedge, then follow the whole schedule
    task automatic run_ramp(input string tag);
        int bad;
        int first_act;
        int first_exp;
        bad = 0;
        trig_uvlo  = 1'b0;
        trig_short = 1'b0;
        for (int n = 0; n < (NS + 2) * DV + 3; n++) begin
            @(negedge clk);
            if (ilim_code != CW'(exp_code(n)) && bad == 0) begin
                first_act = ilim_code;
                first_exp = exp_code(n);
                bad = 1;
            end
        end
        chk(bad == 0, tag, bad ? first_act : ilim_code, bad ? first_exp : NM);
    endtask

    task automatic t_reset();
        chk(ilim_code == CW'(FL), "R1 reset code", ilim_code, FL);
        chk(skip_pulse == 1'b0, "R1 reset skip", skip_pulse, 0);
    endtask

    task automatic t_hold();
        trig_uvlo = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(ilim_code == CW'(FL), "R2 hold uvlo", ilim_code, FL);
        end
        trig_uvlo  = 1'b0;
        trig_short = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ilim_code == CW'(FL), "R2 hold short", ilim_code, FL);
        end
    endtask

    task automatic t_ramp();
        run_ramp("R3 R4 ramp schedule");
        repeat (10) @(negedge clk);
        chk(ilim_code == CW'(NM), "R4 normal level held", ilim_code, NM);
    endtask

    task automatic t_retrigger();
        trig_short = 1'b1;
        @(negedge clk);
        chk(ilim_code == CW'(FL), "R5 trigger from run", ilim_code, FL);
        trig_short = 1'b0;
        repeat (2 * DV + 2) @(negedge clk);
        chk(ilim_code == CW'(FL + 2 * STP), "R5 mid ramp level", ilim_code, FL + 2 * STP);
        trig_uvlo = 1'b1;
        @(negedge clk);
        chk(ilim_code == CW'(FL), "R5 retrigger to floor", ilim_code, FL);
        @(negedge clk);
        run_ramp("R5 timer restart");
    endtask

    task automatic strobe(input int d, input int exp, input string tag);
        cyc_start = 1'b1;
        duty_meas = DW'(d);
        @(negedge clk);
        cyc_start = 1'b0;
        chk(skip_pulse == exp[0], tag, skip_pulse, exp);
    endtask

    task automatic t_skip();
        strobe(THR - 1, 1, "R6 duty just below fraction");
        strobe(THR, 0, "R7 duty at fraction");
        strobe(0, 1, "R6 zero duty");
        strobe(THR - 1, 1, "R6 stays skipped");
        strobe(255, 0, "R7 full duty resumes");
        strobe(3, 1, "R6 light again");
        duty_meas  = DW'(200);
        trig_short = 1'b1;
        repeat (3) @(negedge clk);
        chk(skip_pulse == 1'b1, "R8 no change between strobes", skip_pulse, 1);
        trig_short = 1'b0;
        duty_meas  = DW'(1);
        @(negedge clk);
        strobe(100, 0, "R7 clear after hold");
        duty_meas = DW'(0);
        repeat (3) @(negedge clk);
        chk(skip_pulse == 1'b0, "R8 low duty without strobe", skip_pulse, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hold();
        t_ramp();
        t_retrigger();
        t_skip();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule